// File: doc/BRIEF.md
# Eight-Channel Common-Period PWM Timer

This block generates eight pulse-width-modulated outputs from one up-counter. All channels therefore share a single period. Each channel compares the counter with its own threshold to set its duty. Software programs the block through a flat 32-bit register bus. One write strobe writes a register, and the read data is a combinational function of the address.

The counter runs from a programmable start value up to a programmable ceiling, then returns to the start value. It advances on qualified clock events. A source selector picks where those events come from: the system clock on every cycle, a fixed-rate strobe, an external strobe, or nothing at all. A power-of-two prescaler divides the selected events.

Each output passes through two per-channel gates in series. The first is a polarity inverter. The second is a mask that holds the pin at its idle level; after reset, every channel is masked. New ceiling and threshold values are held in shadow registers while the counter runs, and are adopted only when the counter wraps.

The counter controller is a two-state machine:
- `CS_HALT` is held while the source field is 0. In this state the prescaler is cleared and the counter keeps its value.
- Transition `HALT->COUNT` is taken once the source field is non-zero.
- `CS_COUNT` divides the selected events and steps the counter.
- Transition `COUNT->HALT` is taken as soon as the source field returns to 0.

Top module: `pwm_shared_timer`

## Requirements
- R1: After reset, the control register, counter, start-value register and output-init register all read 0. The mask register reads 0xFF, and every output is 0.
- R2: The counter takes the values start..ceiling and then returns to the start value. Each counter value lasts 2^P counting events, where P is control bits 2:0. The full period is therefore (ceiling-start+1)*2^P events.
- R3: Control bits 4:3 select the counting event. 0 = stopped, with the counter holding its value. 1 = every system clock. 2 = the fixed strobe input. 3 = the external strobe input.
- R4: A channel produces PWM only when both bits 5 and 3 of its mode register are set. It is then active (1 before polarity) while the counter is below its compare value. In any other mode the channel is inactive.
- R5: A compare value of 0 gives 0% duty. A compare value above the ceiling gives 100% duty.
- R6: Setting bit n of the polarity register inverts output n.
- R7: When bit n of the mask register is set, output n equals polarity bit n (its idle level), whatever the counter and compare values are.
- R8: While the counter runs, a new ceiling or compare value takes effect only at the next wrap. While the counter is stopped, it takes effect at once.
- R9: The register map is as follows:
  - 0x00: control
  - 0x04: counter (read-only; writes are ignored)
  - 0x08: ceiling
  - 0x0C+8n: mode of channel n
  - 0x10+8n: compare value of channel n
  - 0x4C: start value
  - 0x5C: output init
  - 0x60: mask
  - 0x70: polarity

  Written values read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fix_tick | input | 1 | Fixed-rate counting strobe, one cycle wide |
| ext_tick | input | 1 | External counting strobe, one cycle wide |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pwm_out | output | 8 | Channel outputs |

## Verification
Random sets of ceiling, start value, prescaler, per-channel compare, polarity and mask values are applied. For each set, the high time of every output is measured over exactly one period. A wrong start value, prescale factor or comparison direction shifts these counts in different ways, so each fault can be told apart from the others. Directed patterns place compare values at zero, just past the ceiling and far past it, and use a mode with only one of its two bits set. The same measurement is repeated with the fixed strobe and the external strobe, and the length of the period shows which event source is actually counted. A threshold write in the middle of a period shows the difference between immediate and wrap-deferred adoption.

// File: rtl/pwmt_pkg.sv
`timescale 1ns/1ps
package pwmt_pkg;

    typedef enum logic {
        CS_HALT  = 1'b0,
        CS_COUNT = 1'b1
    } cnt_state_e;

    typedef enum logic [1:0] {
        SRC_OFF = 2'd0,
        SRC_SYS = 2'd1,
        SRC_FIX = 2'd2,
        SRC_EXT = 2'd3
    } clk_src_e;

    localparam logic [7:0] OFF_CTRL    = 8'h00;
    localparam logic [7:0] OFF_CNT     = 8'h04;
    localparam logic [7:0] OFF_MOD     = 8'h08;
    localparam logic [7:0] OFF_CH_MODE = 8'h0C;
    localparam logic [7:0] OFF_CH_CMP  = 8'h10;
    localparam int         CH_STRIDE   = 8;
    localparam logic [7:0] OFF_INIT    = 8'h4C;
    localparam logic [7:0] OFF_OINIT   = 8'h5C;
    localparam logic [7:0] OFF_MASK    = 8'h60;
    localparam logic [7:0] OFF_POL     = 8'h70;

    localparam int SRC_LSB       = 3;
    localparam int MODE_EDGE_BIT = 5;
    localparam int MODE_HIGH_BIT = 3;

    function automatic logic [7:0] ch_mode_addr(input int n);
        return 8'(int'(OFF_CH_MODE) + CH_STRIDE * n);
    endfunction

    function automatic logic [7:0] ch_cmp_addr(input int n);
        return 8'(int'(OFF_CH_CMP) + CH_STRIDE * n);
    endfunction

endpackage

// File: rtl/pwmt_tick_gen.sv
`timescale 1ns/1ps
module pwmt_tick_gen
    import pwmt_pkg::*;
#(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      src,
    input  logic [PS_W-1:0] ps,
    input  logic            fix_tick,
    input  logic            ext_tick,
    output logic            adv
);
    localparam int PRE_W = (1 << PS_W) - 1;

    cnt_state_e       state_q, state_d;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_lim;
    logic             event_sel;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_HALT:  if (src != SRC_OFF) state_d = CS_COUNT;
            CS_COUNT: if (src == SRC_OFF) state_d = CS_HALT;
            default:  state_d = CS_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_HALT;
        else        state_q <= state_d;
    end

    // outputs: selected event and prescaler terminal count
    always_comb begin
        unique case (src)
            SRC_SYS: event_sel = 1'b1;
            SRC_FIX: event_sel = fix_tick;
            SRC_EXT: event_sel = ext_tick;
            default: event_sel = 1'b0;
        endcase
        pre_lim = (PRE_W'(1) << ps) - PRE_W'(1);
        adv     = (state_q == CS_COUNT) && event_sel && (pre_q >= pre_lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    pre_q <= '0;
        else if (state_q == CS_HALT)   pre_q <= '0;
        else if (event_sel) begin
            if (pre_q >= pre_lim)      pre_q <= '0;
            else                       pre_q <= pre_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/pwmt_counter.sv
`timescale 1ns/1ps
module pwmt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             running,
    input  logic [CNT_W-1:0] mod_wr,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] mod_act,
    output logic             wrap,
    output logic             load
);
    assign wrap = adv && (cnt_q >= mod_act);
    assign load = !running || wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (adv) begin
            if (wrap) cnt_q <= init_val;
            else      cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    mod_act <= '0;
        else if (load) mod_act <= mod_wr;
    end
endmodule

// File: rtl/pwmt_channel.sv
`timescale 1ns/1ps
module pwmt_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_wr,
    input  logic             pwm_mode,
    input  logic             pol,
    input  logic             mask,
    output logic             out,
    output logic [CNT_W-1:0] cmp_act
);
    logic active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cmp_act <= '0;
        else if (load) cmp_act <= cmp_wr;
    end

    assign active = pwm_mode && (cnt < cmp_act);
    assign out    = mask ? pol : (active ^ pol);
endmodule

// File: rtl/pwm_shared_timer.sv
`timescale 1ns/1ps
module pwm_shared_timer
    import pwmt_pkg::*;
#(
    parameter int N_CH  = 8,
    parameter int CNT_W = 16,
    parameter int PS_W  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fix_tick,
    input  logic            ext_tick,
    input  logic            bus_wr,
    input  logic [7:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic [N_CH-1:0] pwm_out
);
    localparam int DW = 32;

    logic [PS_W-1:0]  ps_q;
    logic [1:0]       src_q;
    logic [CNT_W-1:0] mod_q, init_q;
    logic [N_CH-1:0]  oinit_q, mask_q, pol_q;
    logic [CNT_W-1:0] cmp_q  [N_CH];
    logic [7:0]       mode_q [N_CH];

    logic             adv, wrap, load;
    logic [CNT_W-1:0] cnt_q, mod_act;
    logic [N_CH*CNT_W-1:0] cmp_act_flat;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata[DW-1:CNT_W];

    // register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q    <= '0;
            src_q   <= SRC_OFF;
            mod_q   <= '0;
            init_q  <= '0;
            oinit_q <= '0;
            mask_q  <= '1;
            pol_q   <= '0;
            for (int n = 0; n < N_CH; n++) begin
                cmp_q[n]  <= '0;
                mode_q[n] <= '0;
            end
        end else if (bus_wr) begin
            case (bus_addr)
                OFF_CTRL: begin
                    ps_q  <= bus_wdata[PS_W-1:0];
                    src_q <= bus_wdata[SRC_LSB+1:SRC_LSB];
                end
                OFF_MOD:   mod_q   <= bus_wdata[CNT_W-1:0];
                OFF_INIT:  init_q  <= bus_wdata[CNT_W-1:0];
                OFF_OINIT: oinit_q <= bus_wdata[N_CH-1:0];
                OFF_MASK:  mask_q  <= bus_wdata[N_CH-1:0];
                OFF_POL:   pol_q   <= bus_wdata[N_CH-1:0];
                default: ;
            endcase
            for (int n = 0; n < N_CH; n++) begin
                if (bus_addr == ch_mode_addr(n)) mode_q[n] <= bus_wdata[7:0];
                if (bus_addr == ch_cmp_addr(n))  cmp_q[n]  <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_CTRL:  bus_rdata = DW'({src_q, ps_q});
            OFF_CNT:   bus_rdata = DW'(cnt_q);
            OFF_MOD:   bus_rdata = DW'(mod_q);
            OFF_INIT:  bus_rdata = DW'(init_q);
            OFF_OINIT: bus_rdata = DW'(oinit_q);
            OFF_MASK:  bus_rdata = DW'(mask_q);
            OFF_POL:   bus_rdata = DW'(pol_q);
            default: ;
        endcase
        for (int n = 0; n < N_CH; n++) begin
            if (bus_addr == ch_mode_addr(n)) bus_rdata = DW'(mode_q[n]);
            if (bus_addr == ch_cmp_addr(n))  bus_rdata = DW'(cmp_q[n]);
        end
    end

    pwmt_tick_gen #(.PS_W(PS_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src_q),
        .ps       (ps_q),
        .fix_tick (fix_tick),
        .ext_tick (ext_tick),
        .adv      (adv)
    );

    pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .running  (src_q != SRC_OFF),
        .mod_wr   (mod_q),
        .init_val (init_q),
        .cnt_q    (cnt_q),
        .mod_act  (mod_act),
        .wrap     (wrap),
        .load     (load)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        pwmt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .cnt      (cnt_q),
            .cmp_wr   (cmp_q[g]),
            .pwm_mode (mode_q[g][MODE_EDGE_BIT] && mode_q[g][MODE_HIGH_BIT]),
            .pol      (pol_q[g]),
            .mask     (mask_q[g]),
            .out      (pwm_out[g]),
            .cmp_act  (cmp_act_flat[g*CNT_W +: CNT_W])
        );
    end
endmodule

// File: rtl/pwmt_checker.sv
`timescale 1ns/1ps
module pwmt_checker #(
    parameter int N_CH  = 8,
    parameter int CNT_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            src_q,
    input logic [CNT_W-1:0]      cnt_q,
    input logic [CNT_W-1:0]      init_q,
    input logic [CNT_W-1:0]      mod_act,
    input logic                  wrap,
    input logic [N_CH-1:0]       mask_q,
    input logic [N_CH-1:0]       pol_q,
    input logic [N_CH-1:0]       pwm_out,
    input logic [N_CH*CNT_W-1:0] cmp_act_flat
);
    logic [N_CH-1:0] zero_cmp;

    for (genvar g = 0; g < N_CH; g++) begin : g_z
        assign zero_cmp[g] = (cmp_act_flat[g*CNT_W +: CNT_W] == '0);
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(init_q)))); // R2

    AST_WRAP_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == $past(init_q))); // R2

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q == 2'b00) |=> $stable(cnt_q)); // R3

    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        ((zero_cmp & ~mask_q & (pwm_out ^ pol_q)) == '0)); // R5

    AST_MASK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwm_out & mask_q) == (pol_q & mask_q))); // R7

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_q != 2'b00) && !wrap) |=> $stable(mod_act)); // R8
endmodule

bind pwm_shared_timer pwmt_checker #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_q        (src_q),
    .cnt_q        (cnt_q),
    .init_q       (init_q),
    .mod_act      (mod_act),
    .wrap         (wrap),
    .mask_q       (mask_q),
    .pol_q        (pol_q),
    .pwm_out      (pwm_out),
    .cmp_act_flat (cmp_act_flat)
);

// File: tb/pwm_shared_timer_tb.sv
`timescale 1ns/1ps
module pwm_shared_timer_tb;
    localparam int N_CH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fix_tick = 1'b0;
    logic        ext_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [N_CH-1:0] pwm_out;

    int n_chk = 0;
    int n_err = 0;
    int fix_ph = 0;
    logic ext_go = 1'b0;
    int cmpv  [N_CH];
    int modev [N_CH];
    int hi    [N_CH];
    logic [31:0] rdv;

    always #2.5 clk = ~clk;

    pwm_shared_timer u_dut (
        .clk(clk), .rst_n(rst_n), .fix_tick(fix_tick), .ext_tick(ext_tick),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    // strobe sources: fixed every 3rd cycle, external every 2nd cycle when enabled
    always @(negedge clk) begin
        fix_ph   <= (fix_ph == 2) ? 0 : fix_ph + 1;
        fix_tick <= (fix_ph == 2);
        ext_tick <= ext_go & ~ext_tick;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    function automatic int exp_hi(input int c, input int m, input int i, input int ps,
                                  input bit pol, input bit msk, input bit pwm_on, input int scale);
        int len, raw, top;
        len = (m - i + 1) << ps;
        if (msk) return (pol ? len : 0) * scale;
        top = (c < m + 1) ? c : m + 1;
        raw = (!pwm_on || top <= i) ? 0 : (top - i) << ps;
        return (pol ? len - raw : raw) * scale;
    endfunction

    task automatic measure(input int ncyc);
        for (int n = 0; n < N_CH; n++) hi[n] = 0;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            #0.5;
            for (int n = 0; n < N_CH; n++) if (pwm_out[n]) hi[n]++;
        end
    endtask

    task automatic run_cfg(input int src, input int m, input int i, input int ps,
                           input logic [7:0] pol, input logic [7:0] msk,
                           input int scale, input string req);
        int len;
        wr(8'h00, 32'h0);
        wr(8'h08, m);
        wr(8'h4C, i);
        for (int n = 0; n < N_CH; n++) begin
            wr(8'(8'h0C + 8 * n), modev[n]);
            wr(8'(8'h10 + 8 * n), cmpv[n]);
        end
        wr(8'h70, pol);
        wr(8'h60, msk);
        wr(8'h00, (src << 3) | ps);
        len = ((m - i + 1) << ps) * scale;
        repeat (2 * len + 20) @(negedge clk);
        measure(len);
        for (int n = 0; n < N_CH; n++) begin
            int e;
            e = exp_hi(cmpv[n], m, i, ps, pol[n], msk[n],
                       modev[n][5] && modev[n][3], scale);
            chk(hi[n] == e, $sformatf("%s ch%0d high cycles", req, n), hi[n], e);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] a, b;
        int guard;
        void'($urandom(32'd20251));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #0.5;

        // R1 reset state
        chk(pwm_out == 8'h00, "R1 outputs after reset", pwm_out, 0);
        rd(8'h60, rdv); chk(rdv == 32'hFF, "R1 mask reset", rdv, 255);
        rd(8'h00, rdv); chk(rdv == 0, "R1 control reset", rdv, 0);
        rd(8'h04, rdv); chk(rdv == 0, "R1 counter reset", rdv, 0);
        rd(8'h4C, rdv); chk(rdv == 0, "R1 start value reset", rdv, 0);
        rd(8'h5C, rdv); chk(rdv == 0, "R1 output init reset", rdv, 0);

        // R9 register map and read-only counter
        wr(8'h08, 32'h1234); rd(8'h08, rdv); chk(rdv == 32'h1234, "R9 ceiling readback", rdv, 32'h1234);
        wr(8'h28, 32'h77);   rd(8'h28, rdv); chk(rdv == 32'h77, "R9 ch3 compare readback", rdv, 32'h77);
        wr(8'h24, 32'h28);   rd(8'h24, rdv); chk(rdv == 32'h28, "R9 ch3 mode readback", rdv, 32'h28);
        wr(8'h04, 32'h55);   rd(8'h04, rdv); chk(rdv == 0, "R9 counter write ignored", rdv, 0);

        // R7 masked outputs sit at polarity level
        wr(8'h70, 32'hA5);
        @(negedge clk); #0.5;
        chk(pwm_out == 8'hA5, "R7 masked outputs follow polarity", pwm_out, 8'hA5);
        wr(8'h70, 32'h0);

        // R2 R4 R6 R7 random configurations on system clock
        for (int it = 0; it < 8; it++) begin
            int m, i, ps;
            m  = 3 + int'($urandom_range(27));
            i  = int'($urandom_range(2));
            ps = int'($urandom_range(3));
            for (int n = 0; n < N_CH; n++) begin
                cmpv[n]  = int'($urandom_range(m + 3));
                modev[n] = 8'h28;
            end
            run_cfg(1, m, i, ps, 8'($urandom), 8'($urandom_range(255)) & 8'h3C, 1, "R2/R6/R7 random");
        end

        // R5 R4 directed duty corners, R6 inversion
        for (int n = 0; n < N_CH; n++) modev[n] = 8'h28;
        cmpv[0] = 0; cmpv[1] = 11; cmpv[2] = 40; cmpv[3] = 5;
        cmpv[4] = 0; cmpv[5] = 11; cmpv[6] = 7;  cmpv[7] = 3;
        modev[3] = 8'h20;
        modev[7] = 8'h08;
        run_cfg(1, 10, 0, 0, 8'h30, 8'h00, 1, "R5/R4 corners");
        chk(hi[0] == 0,  "R5 zero compare gives 0%",   hi[0], 0);
        chk(hi[1] == 11, "R5 compare above ceiling full", hi[1], 11);
        chk(hi[3] == 0,  "R4 single-bit mode inactive", hi[3], 0);
        chk(hi[4] == 11, "R6 inverted zero duty",       hi[4], 11);

        // R3 fixed strobe (every 3 cycles) and external strobe (every 2 cycles)
        for (int n = 0; n < N_CH; n++) begin cmpv[n] = 2 + n; modev[n] = 8'h28; end
        run_cfg(2, 9, 1, 1, 8'h00, 8'h00, 3, "R3 fixed strobe");
        ext_go = 1'b1;
        run_cfg(3, 7, 0, 2, 8'h81, 8'h00, 2, "R3 external strobe");
        ext_go = 1'b0;
        repeat (4) @(negedge clk);
        rd(8'h04, a); repeat (20) @(negedge clk); rd(8'h04, b);
        chk(a == b, "R3 external source without strobes holds", b, a);
        wr(8'h00, 32'h08);
        repeat (10) @(negedge clk);
        wr(8'h00, 32'h00);
        rd(8'h04, a); repeat (20) @(negedge clk); rd(8'h04, b);
        chk(a == b, "R3 stopped counter holds", b, a);

        // R8 compare write while running is deferred to the wrap
        wr(8'h08, 20); wr(8'h4C, 0); wr(8'h0C, 8'h28); wr(8'h10, 5);
        wr(8'h70, 0);  wr(8'h60, 8'hFE); wr(8'h00, 32'h08);
        guard = 0; do begin rd(8'h04, rdv); guard++; end while (rdv != 2 && guard < 200);
        wr(8'h10, 15);
        guard = 0; do begin rd(8'h04, rdv); guard++; end while (rdv != 10 && guard < 200);
        chk(pwm_out[0] == 1'b0, "R8 old compare kept before wrap", pwm_out[0], 0);
        guard = 0; do begin rd(8'h04, rdv); guard++; end while (rdv != 0 && guard < 200);
        guard = 0; do begin rd(8'h04, rdv); guard++; end while (rdv != 10 && guard < 200);
        chk(pwm_out[0] == 1'b1, "R8 new compare after wrap", pwm_out[0], 1);

        finish_run();
    end
endmodule